// File: doc/BRIEF.md
# Byte-Latched Program Counter

This block holds the 21-bit instruction address of an 8-bit controller whose instructions are 16 bits wide. The address is even at all times. The instruction sequencer moves it forward by two per instruction, or loads a full target address in one step for jumps and calls.

Software reaches the counter only through its low byte. The two upper parts, bits 15:8 and bits 20:16, are never written directly. Software stages new values for them in two holding latches. Any write to the low byte then moves both latches into the counter in the same cycle. Going the other way, a read of the low byte copies the current upper parts into the latches, so that software can read them from there. Together these two rules let software build a computed branch across the whole address space.

A two-flop synchronizer releases the asynchronous reset on a clock edge. The counter and latches stay cleared until two clock edges after the reset input goes high.

Top module: `pcl_top`

## Requirements
- R1: After reset the counter reads 0, the middle latch reads 0 and the upper latch reads 0.
- R2: When `seq_adv` is the only counter command, the counter increases by 2 on the next edge and wraps modulo 2^21 (0x1FFFFE is followed by 0x000000).
- R3: When `seq_load` is the winning command, the counter takes `seq_target` with bit 0 forced to 0. Neither latch changes because of the load.
- R4: When `sfr_lo_we` is asserted, the counter becomes {upper latch, middle latch, `sfr_wdata[7:1]`, 0}. The latch values used are those held before that edge.
- R5: When `sfr_lo_re` is asserted, the middle latch takes counter bits 15:8 and the upper latch takes counter bits 20:16, as they stood before the edge. The read alone does not change the counter.
- R6: `sfr_mid_we` loads the middle latch with `sfr_wdata[7:0]`, and `sfr_top_we` loads the upper latch with `sfr_wdata[4:0]`. Neither write changes the counter. A latch with no write and no read copy keeps its value.
- R7: Counter command priority is low-byte write, then target load, then advance.
- R8: When a direct latch write and a low-byte read occur in the same cycle, that latch takes the written data. The other latch still takes the copy.
- R9: Bit 0 of the counter is 0 at all times, including after a low-byte write of odd data and after a load of an odd target.
- R10: With no counter command the counter holds its value.
- R11: `sfr_lo_rdata` always equals counter bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seq_adv | input | 1 | Advance the counter by one instruction (+2) |
| seq_load | input | 1 | Load the counter from `seq_target` |
| seq_target | input | 21 | Jump or call target address |
| sfr_wdata | input | 8 | Register write data |
| sfr_lo_we | input | 1 | Low-byte write; transfers both latches into the counter |
| sfr_lo_re | input | 1 | Low-byte read strobe; copies the upper parts into the latches |
| sfr_mid_we | input | 1 | Middle latch write |
| sfr_top_we | input | 1 | Upper latch write |
| pc_q | output | 21 | Current counter value |
| sfr_lo_rdata | output | 8 | Low-byte read data |
| lat_mid_q | output | 8 | Middle latch contents |
| lat_top_q | output | 5 | Upper latch contents |

## Verification
The hardest states to reach are ones where the upper parts carry values that a sequential advance would take millions of cycles to produce. Two cases matter most. The first is the wrap at 0x1FFFFE. The second is a low-byte write that changes bits 20:16 while the latches hold values different from the live counter. The stimulus reaches them with target loads to chosen addresses and with direct latch writes of random data, mixed with random low-byte reads and writes. Directed cycles then fire several strobes at once to exercise both precedence rules.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ADV  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_LOWR = 2'd3
  } pc_src_e;
endpackage

// File: rtl/pcl_rst_sync.sv
module pcl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pcl_latch.sv
module pcl_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cap_en,
  input  logic [W-1:0] cap_data,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = wr_en | cap_en;
    d  = wr_en ? wr_data : cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
  import pcl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        target,
  input  logic                     lo_we,
  input  logic [BYTE_W-1:0]        lo_wdata,
  input  logic [ADDR_W-BYTE_W-1:0] upper_src,
  output logic [ADDR_W-1:0]        pc
);
  localparam int STEP = 2;

  pc_src_e           src;
  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;

  always_comb begin
    if (lo_we)     src = SRC_LOWR;
    else if (load) src = SRC_LOAD;
    else if (adv)  src = SRC_ADV;
    else           src = SRC_HOLD;
  end

  always_comb begin
    pc_en = (src != SRC_HOLD);
    unique case (src)
      SRC_LOWR: pc_d = {upper_src, lo_wdata[BYTE_W-1:1], 1'b0};
      SRC_LOAD: pc_d = {target[ADDR_W-1:1], 1'b0};
      SRC_ADV:  pc_d = pc + ADDR_W'(STEP);
      default:  pc_d = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= '0;
    else if (pc_en) pc <= pc_d;
  end
endmodule

// File: rtl/pcl_top.sv
module pcl_top #(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8,
  localparam int MID_W = BYTE_W,
  localparam int TOP_W = ADDR_W - 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_adv,
  input  logic              seq_load,
  input  logic [ADDR_W-1:0] seq_target,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic              sfr_lo_we,
  input  logic              sfr_lo_re,
  input  logic              sfr_mid_we,
  input  logic              sfr_top_we,
  output logic [ADDR_W-1:0] pc_q,
  output logic [BYTE_W-1:0] sfr_lo_rdata,
  output logic [MID_W-1:0]  lat_mid_q,
  output logic [TOP_W-1:0]  lat_top_q
);
  logic rst_sync_n;

  pcl_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcl_latch #(.W(MID_W)) i_lat_mid (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (sfr_mid_we),
    .wr_data  (sfr_wdata),
    .cap_en   (sfr_lo_re),
    .cap_data (pc_q[2*BYTE_W-1:BYTE_W]),
    .q        (lat_mid_q)
  );

  pcl_latch #(.W(TOP_W)) i_lat_top (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (sfr_top_we),
    .wr_data  (sfr_wdata[TOP_W-1:0]),
    .cap_en   (sfr_lo_re),
    .cap_data (pc_q[ADDR_W-1:2*BYTE_W]),
    .q        (lat_top_q)
  );

  pcl_counter #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (seq_adv),
    .load      (seq_load),
    .target    (seq_target),
    .lo_we     (sfr_lo_we),
    .lo_wdata  (sfr_wdata),
    .upper_src ({lat_top_q, lat_mid_q}),
    .pc        (pc_q)
  );

  assign sfr_lo_rdata = pc_q[BYTE_W-1:0];
endmodule

// File: rtl/pcl_top_chk.sv
module pcl_top_chk #(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8,
  localparam int TOP_W = ADDR_W - 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_adv,
  input logic              seq_load,
  input logic [ADDR_W-1:0] seq_target,
  input logic [BYTE_W-1:0] sfr_wdata,
  input logic              sfr_lo_we,
  input logic              sfr_lo_re,
  input logic              sfr_mid_we,
  input logic              sfr_top_we,
  input logic [ADDR_W-1:0] pc_q,
  input logic [BYTE_W-1:0] lat_mid_q,
  input logic [TOP_W-1:0]  lat_top_q
);
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0); // R9

  AST_LOWR_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_lo_we |=> pc_q == {$past(lat_top_q), $past(lat_mid_q), $past(sfr_wdata[BYTE_W-1:1]), 1'b0}); // R4

  AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_load && !sfr_lo_we) |=> pc_q == {$past(seq_target[ADDR_W-1:1]), 1'b0}); // R3

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_adv && !seq_load && !sfr_lo_we) |=> pc_q == $past(pc_q) + ADDR_W'(2)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_adv && !seq_load && !sfr_lo_we) |=> $stable(pc_q)); // R10

  AST_RD_COPY_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_lo_re && !sfr_mid_we) |=> lat_mid_q == $past(pc_q[2*BYTE_W-1:BYTE_W])); // R5

  AST_RD_COPY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_lo_re && !sfr_top_we) |=> lat_top_q == $past(pc_q[ADDR_W-1:2*BYTE_W])); // R5

  AST_MID_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_mid_we |=> lat_mid_q == $past(sfr_wdata)); // R8

  AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_lo_re && !sfr_mid_we && !sfr_top_we) |=> ($stable(lat_mid_q) && $stable(lat_top_q))); // R6
endmodule

bind pcl_top pcl_top_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_pcl_top_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .seq_adv    (seq_adv),
  .seq_load   (seq_load),
  .seq_target (seq_target),
  .sfr_wdata  (sfr_wdata),
  .sfr_lo_we  (sfr_lo_we),
  .sfr_lo_re  (sfr_lo_re),
  .sfr_mid_we (sfr_mid_we),
  .sfr_top_we (sfr_top_we),
  .pc_q       (pc_q),
  .lat_mid_q  (lat_mid_q),
  .lat_top_q  (lat_top_q)
);

// File: tb/test_pcl_top.sv
module test_pcl_top;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seq_adv = 1'b0, seq_load = 1'b0;
  logic [AW-1:0] seq_target = '0;
  logic [7:0]    sfr_wdata = '0;
  logic          sfr_lo_we = 1'b0, sfr_lo_re = 1'b0, sfr_mid_we = 1'b0, sfr_top_we = 1'b0;
  logic [AW-1:0] pc_q;
  logic [7:0]    sfr_lo_rdata, lat_mid_q;
  logic [4:0]    lat_top_q;

  int n_run = 0;
  int n_fail = 0;

  logic [AW-1:0] m_pc = '0;
  logic [7:0]    m_mid = '0;
  logic [4:0]    m_top = '0;

  always #2.5 clk = ~clk;

  pcl_top i_pcl_top (
    .clk(clk), .rst_n(rst_n), .seq_adv(seq_adv), .seq_load(seq_load),
    .seq_target(seq_target), .sfr_wdata(sfr_wdata), .sfr_lo_we(sfr_lo_we),
    .sfr_lo_re(sfr_lo_re), .sfr_mid_we(sfr_mid_we), .sfr_top_we(sfr_top_we),
    .pc_q(pc_q), .sfr_lo_rdata(sfr_lo_rdata), .lat_mid_q(lat_mid_q), .lat_top_q(lat_top_q)
  );

  function automatic logic [AW-1:0] exp_pc(logic [AW-1:0] pc, logic [4:0] t, logic [7:0] m,
      logic lw, logic [7:0] wd, logic ld, logic [AW-1:0] tg, logic adv);
    if (lw)       return {t, m, wd[7:1], 1'b0};
    else if (ld)  return {tg[AW-1:1], 1'b0};
    else if (adv) return pc + AW'(2);
    return pc;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string pc_req, string lat_req);
    check(pc_req, 32'(pc_q), 32'(m_pc));
    check("R9", 32'(pc_q[0]), 32'd0);
    check("R11", 32'(sfr_lo_rdata), 32'(m_pc[7:0]));
    check(lat_req, 32'(lat_mid_q), 32'(m_mid));
    check(lat_req, 32'(lat_top_q), 32'(m_top));
  endtask

  task automatic cyc(logic adv, logic ld, logic [AW-1:0] tg, logic [7:0] wd,
                     logic lw, logic rd, logic mw, logic tw, string pc_req, string lat_req);
    logic [AW-1:0] npc;
    logic [7:0]    nmid;
    logic [4:0]    ntop;
    seq_adv = adv; seq_load = ld; seq_target = tg; sfr_wdata = wd;
    sfr_lo_we = lw; sfr_lo_re = rd; sfr_mid_we = mw; sfr_top_we = tw;
    npc  = exp_pc(m_pc, m_top, m_mid, lw, wd, ld, tg, adv);
    nmid = mw ? wd : (rd ? m_pc[15:8] : m_mid);
    ntop = tw ? wd[4:0] : (rd ? m_pc[20:16] : m_top);
    @(posedge clk);
    @(negedge clk);
    m_pc = npc; m_mid = nmid; m_top = ntop;
    check_all(pc_req, lat_req);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1", "R1");

    // R2 wrap at top of the address space
    cyc(0, 1, 21'h1FFFFE, 8'h00, 0, 0, 0, 0, "R3", "R3");
    cyc(1, 0, '0, 8'h00, 0, 0, 0, 0, "R2", "R6");
    // R3/R9 odd target is forced even
    cyc(0, 1, 21'h0ABCD7, 8'h00, 0, 0, 0, 0, "R3", "R3");
    // R6 latch writes leave pc alone
    cyc(0, 0, '0, 8'hAB, 0, 0, 1, 0, "R10", "R6");
    cyc(0, 0, '0, 8'hFF, 0, 0, 0, 1, "R10", "R6");
    // R4 odd data, both latches transferred
    cyc(0, 0, '0, 8'hFF, 1, 0, 0, 0, "R4", "R6");
    check("R4", 32'(pc_q), 32'h1FABFE);
    // R5 read copy
    cyc(0, 1, 21'h12345A, 8'h00, 0, 0, 0, 0, "R3", "R3");
    cyc(0, 0, '0, 8'h00, 0, 1, 0, 0, "R5", "R5");
    check("R5", 32'(lat_mid_q), 32'h34);
    check("R5", 32'(lat_top_q), 32'h12);
    // R7 all three counter commands at once
    cyc(1, 1, 21'h000100, 8'h21, 1, 0, 0, 0, "R7", "R6");
    cyc(1, 1, 21'h000100, 8'h21, 0, 0, 0, 0, "R7", "R6");
    // R8 latch write beats read copy
    cyc(0, 0, '0, 8'h5C, 0, 1, 1, 0, "R10", "R8");
    cyc(0, 0, '0, 8'h07, 0, 1, 0, 1, "R10", "R8");
    // R5 read alongside advance copies pre-advance bytes
    cyc(0, 1, 21'h03FFFE, 8'h00, 0, 0, 0, 0, "R3", "R3");
    cyc(1, 0, '0, 8'h00, 0, 1, 0, 0, "R2", "R5");

    for (int i = 0; i < 3000; i++) begin
      logic adv, ld, lw, rd, mw, tw;
      string pr, lr;
      adv = ($urandom % 4) != 0;
      ld  = ($urandom % 8) == 0;
      lw  = ($urandom % 8) == 0;
      rd  = ($urandom % 6) == 0;
      mw  = ($urandom % 6) == 0;
      tw  = ($urandom % 6) == 0;
      pr = lw ? "R4" : (ld ? "R3" : (adv ? "R2" : "R10"));
      lr = (mw || tw) ? ((rd) ? "R8" : "R6") : (rd ? "R5" : "R6");
      cyc(adv, ld, AW'($urandom), 8'($urandom), lw, rd, mw, tw, pr, lr);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule